// File: doc/BRIEF.md
# Burst Read Wait-State Generator

This block produces the ready indication that a synchronous burst read from a 16-bit-wide flash array presents to the host. A burst opens when the host pulses `burst_start` while the device is selected. The block then holds the ready output low for a fixed initial latency. After that it counts up one word address on every clock in which a word is handed over.

The internal array is organised in 64-word rows. Every time the burst has just handed over a word whose low six address bits are all ones (3Fh, 7Fh, ...), ready drops for a short pause. A configuration write picks whether that pause lasts one clock or two. A new setting applies from the next burst start, so it never changes a burst that is already running.

Only chip select governs the ready pin. While the device is deselected, the pin's drive enable is off, which stands for the high-impedance state. Deselection also ends any burst in progress. After reselection, ready stays low until a new burst start.

Top module: `burst_wait_gen`

## Requirements
- R1: After reset `data_ok` is 0, no burst is active and the pause mode is the one-clock mode.
- R2: A `burst_start` pulse seen with `chip_sel` high makes `data_ok` low for exactly `LAT` clocks (default 4), counted from the next clock. After that, `data_ok` is high and `word_addr` equals `start_addr`.
- R3: Each clock with `data_ok` high delivers the word at `word_addr`, and at the next clock `word_addr` has advanced by one. The address wraps from all ones to zero.
- R4: In one-clock mode, after the word whose `word_addr[5:0]` is 6'h3F is delivered, `data_ok` is low for exactly one clock. The next word is then delivered with the address advanced by one.
- R5: In two-clock mode, the same 6'h3F crossing makes `data_ok` low for exactly two clocks.
- R6: A clock with `cfg_wr` high stores `cfg_two_wait` as the pause mode (1 = two clocks, 0 = one clock). A burst uses the mode stored before its `burst_start` clock, and a write made during a burst does not change that burst.
- R7: `data_ok_en` follows `chip_sel` with no clock delay. A clock with `chip_sel` low ends the burst, and `data_ok` stays low afterwards until a new burst start.
- R8: A `burst_start` during a running burst restarts it at the new `start_addr`, with a full `LAT`-clock initial latency.
- R9: A `burst_start` pulse with `chip_sel` low is ignored, and `data_ok` stays low once chip select returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_sel | input | 1 | Device selected (active high) |
| burst_start | input | 1 | One-clock strobe opening a burst at `start_addr` |
| start_addr | input | ADDR_W | First word address of the burst |
| cfg_wr | input | 1 | Configuration write strobe for the pause mode |
| cfg_two_wait | input | 1 | Pause mode written by `cfg_wr`: 1 = two clocks, 0 = one clock |
| data_ok | output | 1 | High: a word is delivered this clock. Low: the host waits |
| data_ok_en | output | 1 | Drive enable of `data_ok`. Low stands for high impedance |
| word_addr | output | ADDR_W | Address of the word delivered when `data_ok` is high |

## Verification
Bursts are started at addresses well inside a 64-word row, so that only the initial latency shows. Others start a few words before a 3Fh crossing in each pause mode, which separates the one-clock from the two-clock pause. A burst that runs across a crossing while the mode is rewritten shows whether the mode is latched per burst or read live. A burst placed just below the top of the address space covers the wrap, where a crossing and the wrap fall on the same step. Deselection mid-burst, a restart mid-burst and a strobe while deselected tell apart a clean abort, a fresh latency and an ignored strobe.

// File: rtl/burst_wait_gen.sv
module burst_wait_gen #(
  parameter int ADDR_W = 23,
  parameter int LAT    = 4,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel,
  input  logic              burst_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              cfg_wr,
  input  logic              cfg_two_wait,
  output logic              data_ok,
  output logic              data_ok_en,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int CNT_W = $clog2(LAT + 3);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

  logic              active;
  logic              mode_two;
  logic              burst_two;
  logic [CNT_W-1:0]  wait_cnt;
  logic [ADDR_W-1:0] addr_q;

  wire row_end = &addr_q[ROW_W-1:0];

  assign data_ok    = active && (wait_cnt == '0);
  assign data_ok_en = chip_sel;
  assign word_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_two <= 1'b0;
    else if (cfg_wr) mode_two <= cfg_two_wait;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      burst_two <= 1'b0;
      wait_cnt  <= '0;
      addr_q    <= '0;
    end else if (!chip_sel) begin
      active   <= 1'b0;
      wait_cnt <= '0;
    end else if (burst_start) begin
      active    <= 1'b1;
      burst_two <= mode_two;
      wait_cnt  <= LAT_C;
      addr_q    <= start_addr;
    end else if (active) begin
      if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
      end else begin
        addr_q <= addr_q + 1'b1;
        if (row_end) wait_cnt <= burst_two ? CNT_W'(2) : CNT_W'(1);
      end
    end
  end

  wire go_on = chip_sel && !burst_start;

  a_r2_latency_low: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && burst_start) |=> !data_ok);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ok && go_on) |=> (word_addr == $past(word_addr) + 1'b1));

  a_r4_row_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ok && row_end && go_on) |=> !data_ok);

  a_r5_second_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ok && active && go_on && burst_two && $past(data_ok && row_end && go_on)) |=> !data_ok);

  a_r6_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && go_on) |=> $stable(burst_two));

  a_r7_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |=> !data_ok);
endmodule

// File: tb/test_burst_wait_gen.sv
module test_burst_wait_gen;
  localparam int AW  = 23;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_sel = 1'b0, burst_start = 1'b0, cfg_wr = 1'b0, cfg_two_wait = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic data_ok, data_ok_en;
  logic [AW-1:0] word_addr;

  always #2 clk = ~clk;

  burst_wait_gen i_burst_wait_gen (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .burst_start(burst_start),
    .start_addr(start_addr), .cfg_wr(cfg_wr), .cfg_two_wait(cfg_two_wait),
    .data_ok(data_ok), .data_ok_en(data_ok_en), .word_addr(word_addr));

  int checks = 0, errors = 0;
  string tag = "R1";

  // behavioural reference
  bit m_act, m_cfg, m_two;
  int m_cnt;
  longint m_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_cfg = 0; m_two = 0; m_cnt = 0; m_addr = 0;
    end else begin
      bit old_cfg;
      old_cfg = m_cfg;
      if (cfg_wr) m_cfg = cfg_two_wait;
      if (!chip_sel) begin
        m_act = 0; m_cnt = 0;
      end else if (burst_start) begin
        m_act = 1; m_cnt = LAT; m_addr = start_addr; m_two = old_cfg;
      end else if (m_act) begin
        if (m_cnt > 0) m_cnt = m_cnt - 1;
        else begin
          if (m_addr % 64 == 63) m_cnt = m_two ? 2 : 1;
          m_addr = (m_addr + 1) % (64'd1 << AW);
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit m_ok;
      m_ok = m_act && (m_cnt == 0);
      chk(data_ok == m_ok, tag, "model data_ok", data_ok, m_ok);
      chk(data_ok_en == chip_sel, "R7", "model data_ok_en", data_ok_en, chip_sel);
      if (m_ok) chk(word_addr == m_addr[AW-1:0], tag, "model word_addr", word_addr, m_addr);
    end
  end

  task automatic tick(bit exp_ok, longint exp_addr, string req);
    @(negedge clk);
    chk(data_ok == exp_ok, req, "data_ok", data_ok, exp_ok);
    if (exp_ok) chk(word_addr == exp_addr[AW-1:0], req, "word_addr", word_addr, exp_addr);
    #1;
  endtask

  task automatic start(longint a, string req);
    burst_start = 1; start_addr = a[AW-1:0];
    tick(0, 0, req);
    burst_start = 0;
    for (int i = 1; i < LAT; i++) tick(0, 0, req);
    tick(1, a, req);
  endtask

  task automatic set_mode(bit two);
    cfg_wr = 1; cfg_two_wait = two;
    @(negedge clk); #1;
    cfg_wr = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #1;
        chk(data_ok == 0, "R1", "reset data_ok", data_ok, 0);
        chk(data_ok_en == 0, "R7", "deselected enable", data_ok_en, 0);
        rst_n = 1;
        @(negedge clk); #1;
        chk(data_ok == 0, "R1", "idle data_ok", data_ok, 0);
        chip_sel = 1; #1;
        chk(data_ok_en == 1, "R7", "enable follows select", data_ok_en, 1);

        tag = "R2"; start(24'h10, "R2");
        tag = "R3"; for (int k = 1; k < 6; k++) tick(1, 24'h10 + k, "R3");

        tag = "R4"; start(24'h3C, "R4");
        tick(1, 24'h3D, "R4"); tick(1, 24'h3E, "R4"); tick(1, 24'h3F, "R4");
        tick(0, 0, "R4"); tick(1, 24'h40, "R4"); tick(1, 24'h41, "R4");

        tag = "R5"; set_mode(1);
        start(24'h17D, "R5");
        tick(1, 24'h17E, "R5"); tick(1, 24'h17F, "R5");
        tick(0, 0, "R5"); tick(0, 0, "R5"); tick(1, 24'h180, "R5");

        tag = "R6"; start(24'h1BE, "R6");
        cfg_wr = 1; cfg_two_wait = 0;
        tick(1, 24'h1BF, "R6");
        cfg_wr = 0;
        tick(0, 0, "R6"); tick(0, 0, "R6"); tick(1, 24'h1C0, "R6");
        start(24'h23F, "R6");
        tick(0, 0, "R6"); tick(1, 24'h240, "R6");

        tag = "R3"; start((64'd1 << AW) - 2, "R3");
        tick(1, (64'd1 << AW) - 1, "R3");
        tick(0, 0, "R3"); tick(1, 0, "R3"); tick(1, 1, "R3");

        tag = "R7"; chip_sel = 0; #1;
        chk(data_ok_en == 0, "R7", "enable drops at once", data_ok_en, 0);
        tick(0, 0, "R7");
        chip_sel = 1;
        for (int k = 0; k < 8; k++) tick(0, 0, "R7");
        start(24'h500, "R7");

        tag = "R8"; tick(1, 24'h501, "R8");
        start(24'h700, "R8");
        tick(1, 24'h701, "R8");

        tag = "R9"; chip_sel = 0; burst_start = 1; start_addr = 24'h900;
        tick(0, 0, "R9");
        burst_start = 0; chip_sel = 1;
        for (int k = 0; k < LAT + 4; k++) tick(0, 0, "R9");

        tag = "R1"; rst_n = 0;
        tick(0, 0, "R1");
        rst_n = 1;
        start(24'h3E, "R1");
        tick(1, 24'h3F, "R1"); tick(0, 0, "R1"); tick(1, 24'h40, "R1");
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule